// File: doc/BRIEF.md
# Bus Clock Divider Setting Calculator

This block works out the clock divider settings for a system in which one core clock feeds a CPU clock, a high-speed bus clock and a peripheral bus clock. After a start pulse it takes four 32-bit frequencies in Hz: the core clock, the CPU clock wanted, the ceiling for the high-speed bus and the ceiling for the peripheral bus. It then walks a fixed ladder of bus divisors, picks a peripheral ratio, and decides whether the CPU should be run from the bus clock in low-voltage mode (called DVS here).

Every division goes through one internal shift-subtract unsigned divider, so a calculation takes several hundred cycles at most. The results are held from the completion flag until the next accepted start. If no legal setting exists, the block reports an invalid result.

Top module: `busdiv_calc`

## Requirements
- R1: The CPU frequency used for the calculation is the requested value limited to the core frequency, so a request above the core frequency behaves as a request equal to it.
- R2: When the limited CPU frequency is below both the core frequency and the bus ceiling, the CPU frequency replaces the bus ceiling for the divisor search.
- R3: Bus divisors are tried in the order 1, 2, 3, 4, 6, 8, and the first one accepted is reported on `bus_div` as its plain binary value. 5 and 7 are never used.
- R4: A divisor is accepted when core/divisor is at or below the ceiling, or lies above it by no more than 1000 Hz.
- R5: If none of the six divisors is accepted, the result is invalid.
- R6: The peripheral ratio starts at 2 when the bus frequency exceeds the peripheral ceiling, and at 1 otherwise. It goes up by one if bus/ratio still exceeds the ceiling. A final ratio above 2 makes the result invalid.
- R7: `per_div` equals the peripheral ratio times the bus divisor.
- R8: The CPU frequency is first raised to the bus frequency if it is lower. If it is then still below the core frequency, `dvs` is 1 and `cpu_hz` equals the bus frequency. Otherwise `dvs` is 0 and `cpu_hz` is that CPU frequency.
- R9: `start` is accepted only when `busy` is low. While busy, `start` is ignored and `done` is low. `done` rises when the result is ready, and `busy` and `done` are never high together.
- R10: From `done` until the next accepted `start`, all result outputs hold their values, whatever the inputs do.
- R11: An invalid result shows `invalid`=1 with `bus_div`, `per_div`, `cpu_hz` and `dvs` all 0.
- R12: Every division truncates and takes exactly 32 divider cycles. `done` comes 70+34·k clock edges after the start edge for accepted divisor position k (0-based), and 205 edges after it when the ladder runs out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calculation (taken only when idle) |
| core_hz | input | 32 | Core clock frequency, Hz |
| cpu_req_hz | input | 32 | Requested CPU clock frequency, Hz |
| bus_lim_hz | input | 32 | High-speed bus clock ceiling, Hz |
| per_lim_hz | input | 32 | Peripheral bus clock ceiling, Hz |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | Result ready and held |
| invalid | output | 1 | No legal setting exists |
| dvs | output | 1 | CPU runs from the bus clock |
| bus_div | output | 4 | Chosen bus divisor (1,2,3,4,6,8) |
| per_div | output | 5 | Peripheral divisor relative to the core clock |
| cpu_hz | output | 32 | Achieved CPU clock frequency, Hz |

## Verification
On every cycle the assertions check that `busy` and `done` are exclusive, that held results do not move, that the divider takes 32 cycles, and that every result has a consistent shape. That means a ladder divisor, a peripheral divisor of one or two times the bus divisor, an all-zero invalid result, and a CPU frequency tied to the core or below it in DVS mode. Whether the right divisor was picked cannot be seen from the shape of the result. That needs the bench scenarios: the window edges at 1000 and 1001 Hz, the skipped 5, the lowered ceiling, the peripheral overflow, clamping, a start ignored mid-run, and the exact completion cycle.

// File: rtl/busdiv_pkg.sv
package busdiv_pkg;
  localparam int LADDER_LEN = 6;
  localparam int IDX_W      = 3;
  localparam int BDIV_W     = 4;
  localparam int RATIO_W    = 2;
  localparam int PDIV_W     = BDIV_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BUS_GO,
    ST_BUS_WAIT,
    ST_PER_GO,
    ST_PER_WAIT,
    ST_FIX
  } calc_state_t;

  // Sparse divisor ladder: 5 and 7 are left out on purpose.
  function automatic logic [BDIV_W-1:0] ladder_step(input int unsigned pos);
    case (pos)
      0:       ladder_step = 4'd1;
      1:       ladder_step = 4'd2;
      2:       ladder_step = 4'd3;
      3:       ladder_step = 4'd4;
      4:       ladder_step = 4'd6;
      default: ladder_step = 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/busdiv_divider.sv
module busdiv_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     rem_q;
  logic [W-1:0]     quo_q;
  logic [W-1:0]     dvs_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W:0]       shifted;
  logic             fits;

  assign shifted  = {rem_q, quo_q[W-1]};
  assign fits     = shifted >= {1'b0, dvs_q};
  assign quotient = quo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        rem_q <= '0;
        quo_q <= dividend;
        dvs_q <= divisor;
        cnt_q <= CNT_W'(W);
      end else if (cnt_q != '0) begin
        if (fits) begin
          rem_q <= W'(shifted - {1'b0, dvs_q});
          quo_q <= {quo_q[W-2:0], 1'b1};
        end else begin
          rem_q <= shifted[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        done  <= (cnt_q == CNT_W'(1));
      end
    end
  end
endmodule

// File: rtl/busdiv_ladder.sv
module busdiv_ladder
  import busdiv_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  output logic [BDIV_W-1:0] step,
  output logic              last
);
  logic [BDIV_W-1:0] table_w [LADDER_LEN];

  for (genvar g = 0; g < LADDER_LEN; g++) begin : g_rung
    assign table_w[g] = ladder_step(g);
  end

  always_comb begin
    step = table_w[LADDER_LEN-1];
    for (int i = 0; i < LADDER_LEN; i++) begin
      if (idx == IDX_W'(i)) step = table_w[i];
    end
  end

  assign last = (idx == IDX_W'(LADDER_LEN - 1));
endmodule

// File: rtl/busdiv_accept.sv
module busdiv_accept #(
  parameter int W      = 32,
  parameter int TOL_HZ = 1000
) (
  input  logic [W-1:0] cand_hz,
  input  logic [W-1:0] ceil_hz,
  output logic         ok
);
  logic [W-1:0] excess;

  assign excess = cand_hz - ceil_hz;
  assign ok     = (cand_hz <= ceil_hz) || (excess <= W'(TOL_HZ));
endmodule

// File: rtl/busdiv_calc.sv
module busdiv_calc
  import busdiv_pkg::*;
#(
  parameter int HZ_W   = 32,
  parameter int TOL_HZ = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [HZ_W-1:0]   core_hz,
  input  logic [HZ_W-1:0]   cpu_req_hz,
  input  logic [HZ_W-1:0]   bus_lim_hz,
  input  logic [HZ_W-1:0]   per_lim_hz,
  output logic              busy,
  output logic              done,
  output logic              invalid,
  output logic              dvs,
  output logic [BDIV_W-1:0] bus_div,
  output logic [PDIV_W-1:0] per_div,
  output logic [HZ_W-1:0]   cpu_hz
);
  function automatic logic [HZ_W-1:0] hz_min(input logic [HZ_W-1:0] a, input logic [HZ_W-1:0] b);
    hz_min = (a < b) ? a : b;
  endfunction

  function automatic logic [HZ_W-1:0] hz_max(input logic [HZ_W-1:0] a, input logic [HZ_W-1:0] b);
    hz_max = (a > b) ? a : b;
  endfunction

  function automatic logic [PDIV_W-1:0] scale_div(input logic [RATIO_W-1:0] r, input logic [BDIV_W-1:0] d);
    scale_div = (r == RATIO_W'(2)) ? {d, 1'b0} : {1'b0, d};
  endfunction

  calc_state_t       state_q;
  logic [HZ_W-1:0]   core_q, cpu_q, lim_q, plim_q, hclk_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BDIV_W-1:0] hdiv_q;
  logic [RATIO_W-1:0] ratio_q;

  // Named internal events, used by the bound checker.
  logic              take_start, div_go, div_done, cand_ok, ladder_end, finish;
  logic [HZ_W-1:0]   div_num, div_den, div_quo;
  logic [BDIV_W-1:0] rung;
  logic [HZ_W-1:0]   cpu_clamped, cpu_fixed;
  logic              want_dvs;
  logic [RATIO_W:0]  ratio_next;

  assign busy       = (state_q != ST_IDLE);
  assign take_start = start && !busy;
  assign div_go     = (state_q == ST_BUS_GO) || (state_q == ST_PER_GO);
  assign div_num    = (state_q == ST_PER_GO) ? hclk_q : core_q;
  assign div_den    = (state_q == ST_PER_GO) ? HZ_W'(ratio_q) : HZ_W'(rung);
  assign cpu_clamped = hz_min(cpu_req_hz, core_hz);
  assign cpu_fixed  = hz_max(cpu_q, hclk_q);
  assign want_dvs   = cpu_fixed < core_q;
  assign ratio_next = (div_quo > plim_q) ? ({1'b0, ratio_q} + 1'b1) : {1'b0, ratio_q};
  assign finish     = (state_q == ST_FIX)
                   || (state_q == ST_BUS_WAIT && div_done && !cand_ok && ladder_end)
                   || (state_q == ST_PER_WAIT && div_done && ratio_next > 3'd2);

  busdiv_divider #(.W(HZ_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (div_go),
    .dividend (div_num),
    .divisor  (div_den),
    .done     (div_done),
    .quotient (div_quo)
  );

  busdiv_ladder u_ladder (
    .idx  (idx_q),
    .step (rung),
    .last (ladder_end)
  );

  busdiv_accept #(.W(HZ_W), .TOL_HZ(TOL_HZ)) u_accept (
    .cand_hz (div_quo),
    .ceil_hz (lim_q),
    .ok      (cand_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      core_q  <= '0;
      cpu_q   <= '0;
      lim_q   <= '0;
      plim_q  <= '0;
      hclk_q  <= '0;
      idx_q   <= '0;
      hdiv_q  <= '0;
      ratio_q <= '0;
      done    <= 1'b0;
      invalid <= 1'b0;
      dvs     <= 1'b0;
      bus_div <= '0;
      per_div <= '0;
      cpu_hz  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (take_start) begin
          core_q  <= core_hz;
          cpu_q   <= cpu_clamped;
          plim_q  <= per_lim_hz;
          lim_q   <= (cpu_clamped < core_hz && cpu_clamped < bus_lim_hz) ? cpu_clamped : bus_lim_hz;
          idx_q   <= '0;
          done    <= 1'b0;
          state_q <= ST_BUS_GO;
        end
        ST_BUS_GO: state_q <= ST_BUS_WAIT;
        ST_BUS_WAIT: if (div_done) begin
          if (cand_ok) begin
            hclk_q  <= div_quo;
            hdiv_q  <= rung;
            ratio_q <= (div_quo > plim_q) ? RATIO_W'(2) : RATIO_W'(1);
            state_q <= ST_PER_GO;
          end else if (!ladder_end) begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_BUS_GO;
          end
        end
        ST_PER_GO: state_q <= ST_PER_WAIT;
        ST_PER_WAIT: if (div_done && ratio_next <= 3'd2) begin
          ratio_q <= ratio_next[RATIO_W-1:0];
          state_q <= ST_FIX;
        end
        default: ;
      endcase

      if (finish) begin
        state_q <= ST_IDLE;
        done    <= 1'b1;
        if (state_q == ST_FIX) begin
          invalid <= 1'b0;
          dvs     <= want_dvs;
          bus_div <= hdiv_q;
          per_div <= scale_div(ratio_q, hdiv_q);
          cpu_hz  <= want_dvs ? hclk_q : cpu_fixed;
        end else begin
          invalid <= 1'b1;
          dvs     <= 1'b0;
          bus_div <= '0;
          per_div <= '0;
          cpu_hz  <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/busdiv_calc_chk.sv
module busdiv_calc_chk
  import busdiv_pkg::*;
#(
  parameter int HZ_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              invalid,
  input logic              dvs,
  input logic [BDIV_W-1:0] bus_div,
  input logic [PDIV_W-1:0] per_div,
  input logic [HZ_W-1:0]   cpu_hz,
  input logic [HZ_W-1:0]   core_q,
  input logic              div_go,
  input logic              div_done
);
  localparam int LAT_W = $clog2(HZ_W + 3);
  logic [LAT_W-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else if (div_go) lat_q <= LAT_W'(1);
    else if (div_done) lat_q <= '0;
    else if (lat_q != '0) lat_q <= lat_q + 1'b1;
  end

  assert_div_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |-> lat_q == LAT_W'(HZ_W + 1));

  assert_busy_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_busy_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> busy || done);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(bus_div) && $stable(per_div)
                       && $stable(cpu_hz) && $stable(dvs) && $stable(invalid));

  assert_ladder_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done && !invalid |-> bus_div inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd8});

  assert_per_scale_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !invalid |-> (per_div == {1'b0, bus_div}) || (per_div == {bus_div, 1'b0}));

  assert_cpu_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done && !invalid |-> cpu_hz <= core_q);

  assert_dvs_below_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !invalid && dvs |-> cpu_hz < core_q);

  assert_full_speed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !invalid && !dvs |-> cpu_hz == core_q);

  assert_invalid_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done && invalid |-> bus_div == '0 && per_div == '0 && cpu_hz == '0 && !dvs);
endmodule

bind busdiv_calc busdiv_calc_chk #(.HZ_W(HZ_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .invalid  (invalid),
  .dvs      (dvs),
  .bus_div  (bus_div),
  .per_div  (per_div),
  .cpu_hz   (cpu_hz),
  .core_q   (core_q),
  .div_go   (div_go),
  .div_done (div_done)
);

// File: tb/busdiv_calc_test.sv
`timescale 1ns/1ps
module busdiv_calc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] core_hz = '0, cpu_req_hz = '0, bus_lim_hz = '0, per_lim_hz = '0;
  logic        busy, done, invalid, dvs;
  logic [3:0]  bus_div;
  logic [4:0]  per_div;
  logic [31:0] cpu_hz;

  int tests = 0;
  int fails = 0;
  bit over  = 0;

  always #2 clk = ~clk;

  busdiv_calc uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .core_hz(core_hz), .cpu_req_hz(cpu_req_hz), .bus_lim_hz(bus_lim_hz), .per_lim_hz(per_lim_hz),
    .busy(busy), .done(done), .invalid(invalid), .dvs(dvs),
    .bus_div(bus_div), .per_div(per_div), .cpu_hz(cpu_hz)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Independent reference: walk 1..8, skip the two odd gaps.
  function automatic void model(input longint core, input longint req, input longint blim,
                                input longint plim, output bit inv, output bit dv,
                                output int bd, output int pd, output longint cpu);
    longint c, lim, q, hz;
    int r;
    c = (req > core) ? core : req;
    lim = (c < core && c < blim) ? c : blim;
    bd = 0; hz = 0; inv = 0; dv = 0; pd = 0; cpu = 0;
    for (int d = 1; d <= 8; d++) begin
      if (d == 5 || d == 7) continue;
      q = core / d;
      if (bd == 0 && (q <= lim || q - lim <= 1000)) begin bd = d; hz = q; end
    end
    if (bd == 0) begin inv = 1; return; end
    r = (hz > plim) ? 2 : 1;
    if (hz / r > plim) r++;
    if (r > 2) begin inv = 1; bd = 0; return; end
    pd = r * bd;
    if (c < hz) c = hz;
    dv = (c < core);
    cpu = dv ? hz : c;
  endfunction

  task automatic launch(input longint core, input longint req, input longint blim,
                        input longint plim, output int edges);
    @(negedge clk);
    core_hz = 32'(core); cpu_req_hz = 32'(req); bus_lim_hz = 32'(blim); per_lim_hz = 32'(plim);
    start = 1'b1;
    edges = 0;
    @(posedge clk); edges++;
    #1 start = 1'b0;
    while (!done) begin
      @(posedge clk); edges++;
      #1;
    end
    @(negedge clk);
  endtask

  task automatic expect_model(input string req, input longint core, input longint cpu_req,
                              input longint blim, input longint plim);
    bit inv, dv; int bd, pd; longint cpu;
    model(core, cpu_req, blim, plim, inv, dv, bd, pd, cpu);
    chk({req, " invalid"}, invalid, inv);
    chk({req, " dvs"}, dvs, dv);
    chk({req, " bus_div"}, bus_div, bd);
    chk({req, " per_div"}, per_div, pd);
    chk({req, " cpu_hz"}, cpu_hz, cpu);
  endtask

  task automatic t_reset();
    chk("R9 reset busy", busy, 0);
    chk("R9 reset done", done, 0);
    chk("R11 reset invalid", invalid, 0);
  endtask

  task automatic t_nominal();
    int e;
    launch(400000000, 400000000, 133333333, 66666666, e);
    expect_model("R3 nominal", 400000000, 400000000, 133333333, 66666666);
    chk("R3 nominal divisor 3", bus_div, 3);
    chk("R7 nominal per_div 6", per_div, 6);
    chk("R12 nominal latency", e, 70 + 34*2);
  endtask

  task automatic t_tolerance();
    int e;
    launch(400000000, 400000000, 133332333, 66666666, e);
    chk("R4 excess 1000 accepted", bus_div, 3);
    expect_model("R4 edge", 400000000, 400000000, 133332333, 66666666);
    launch(400000000, 400000000, 133332332, 66666666, e);
    chk("R4 excess 1001 rejected", bus_div, 4);
    expect_model("R4 beyond", 400000000, 400000000, 133332332, 66666666);
  endtask

  task automatic t_dvs();
    int e;
    launch(400000000, 100000000, 133333333, 66666666, e);
    chk("R2 lowered ceiling divisor", bus_div, 4);
    chk("R8 dvs set", dvs, 1);
    chk("R8 cpu equals bus", cpu_hz, 100000000);
    expect_model("R2 dvs", 400000000, 100000000, 133333333, 66666666);
    launch(400000000, 133332900, 200000000, 66666666, e);
    chk("R8 cpu raised to bus", cpu_hz, 133333333);
    expect_model("R8 raise", 400000000, 133332900, 200000000, 66666666);
    launch(400000000, 150000000, 133333333, 66666666, e);
    chk("R2 ceiling kept when cpu above it", bus_div, 3);
    expect_model("R8 dvs above ceiling", 400000000, 150000000, 133333333, 66666666);
  endtask

  task automatic t_clamp();
    int e;
    launch(400000000, 500000000, 133333333, 66666666, e);
    chk("R1 clamp cpu", cpu_hz, 400000000);
    chk("R1 clamp no dvs", dvs, 0);
  endtask

  task automatic t_skip();
    int e;
    launch(500000000, 500000000, 100500000, 200000000, e);
    chk("R3 five skipped", bus_div, 6);
    chk("R6 ratio 1", per_div, 6);
    chk("R12 position 4 latency", e, 70 + 34*4);
    expect_model("R3 skip", 500000000, 500000000, 100500000, 200000000);
    launch(80000000, 80000000, 80000000, 80000000, e);
    chk("R12 first rung latency", e, 70);
    chk("R3 divisor 1", bus_div, 1);
  endtask

  task automatic t_invalid();
    int e;
    launch(400000000, 400000000, 10000000, 5000000, e);
    chk("R5 ladder exhausted", invalid, 1);
    chk("R11 zero bus_div", bus_div, 0);
    chk("R11 zero cpu", cpu_hz, 0);
    chk("R12 exhaust latency", e, 205);
    launch(100000000, 100000000, 100000000, 40000000, e);
    chk("R6 ratio overflow invalid", invalid, 1);
    chk("R11 zero per_div", per_div, 0);
    chk("R11 zero dvs", dvs, 0);
    launch(100000000, 100000000, 100000000, 50000000, e);
    chk("R6 ratio 2 fits", invalid, 0);
    chk("R6 per_div 2", per_div, 2);
  endtask

  task automatic t_start_busy();
    @(negedge clk);
    core_hz = 400000000; cpu_req_hz = 400000000; bus_lim_hz = 133333333; per_lim_hz = 66666666;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    core_hz = 100000000; bus_lim_hz = 10000000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 busy during run", busy, 1);
    chk("R9 done low while busy", done, 0);
    while (!done) @(negedge clk);
    chk("R9 mid-run start ignored", bus_div, 3);
    chk("R9 mid-run start ignored cpu", cpu_hz, 400000000);
  endtask

  task automatic t_hold();
    logic [3:0] b; logic [4:0] p; logic [31:0] c;
    b = bus_div; p = per_div; c = cpu_hz;
    core_hz = 123; cpu_req_hz = 7; bus_lim_hz = 1; per_lim_hz = 1;
    repeat (50) @(negedge clk);
    chk("R10 done held", done, 1);
    chk("R10 bus_div held", bus_div, b);
    chk("R10 per_div held", per_div, p);
    chk("R10 cpu held", cpu_hz, c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_nominal();
    t_tolerance();
    t_dvs();
    t_clamp();
    t_skip();
    t_invalid();
    t_start_busy();
    t_hold();
    if (!over) begin
      over = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!over) begin
      over = 1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule